// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Sequencer

This block is the sequencing engine of one DMA channel. A descriptor (a transfer-control word plus source and destination base addresses) is captured on a load strobe. The engine then issues a stream of transfer requests. Each request carries a source address, a destination address and a width. After each accepted request it advances both addresses and counts the remaining transfers down. Memory access, the bus fabric and arbitration between channels belong to the surrounding system. Arbitration receives the channel priority as an exported field.

Transfers start on a software trigger held in the descriptor or on a hardware trigger input. The hardware trigger is conditioned by a selectable polarity and by edge or level sensing. Each trigger launches either one transfer or a burst of 2^n transfers. Each side can wrap its address back to the start of the burst. An optional peripheral request input paces every transfer.

When the descriptor is used up, the engine pulses completion flag A and/or B. It can then ask for the next descriptor through a reload request/acknowledge handshake. An abort drops everything in flight.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, req_valid, done_a, done_b and reload_req are low, and chan_stat is 0.
- R2: A load pulse with transfer-control bit 0 (valid) and bit 2 (software trigger) set makes chan_stat equal 3'b101 (bit 0 valid-pending, bit 2 trigger set). The first req_valid appears two rising edges after the load edge.
- R3: Transfer-control bits 25:16 hold the transfer count minus one. Exactly that count plus one requests (1 to 1024) are accepted before the channel stops.
- R4: Transfer-control bits 9:8 give the width code: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. Bits 13:12 (source) and 15:14 (destination) give an increment code: 0, 1, 2 or 3 means a step of 0, 1, 2 or 4 times the width in bytes after each accepted request.
- R5: Configuration bit 1 enables the hardware trigger, which is taken only while a valid descriptor is held. Bit 4 selects polarity (1 is high or rising, 0 is low or falling) and bit 5 selects level (1) or edge (0). In hardware mode each edge is consumed by one burst. A level trigger keeps bursts going only while it stays active.
- R6: Configuration bit 6 set makes each trigger run a burst of 2^n requests, with n taken from configuration bits 11:8 and limited to 10. Clear, each trigger runs one request.
- R7: Configuration bit 14 (source) and bit 15 (destination) make that address return to its burst start value after the last request of each burst.
- R8: With configuration bit 0 set, req_valid stays low while periph_req is low.
- R9: On the last request of a descriptor, valid-pending clears. Transfer-control bit 4 yields one done_a pulse and bit 5 one done_b pulse. Bit 3 clears the trigger flag; without bit 3 the flag stays set.
- R10: With transfer-control bit 1 set, reload_req rises at the end of the descriptor and holds until reload_ack. The acknowledge loads the descriptor presented on the inputs at that time.
- R11: abort lowers req_valid at once and clears valid-pending, the trigger flag and the remaining count. Re-enabling the channel afterwards issues no further request.
- R12: chan_en low holds req_valid low without losing the channel state. chan_prio mirrors configuration bits 17:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable, gates request issue |
| cfg_word | input | 32 | Channel configuration word |
| xfer_word | input | 32 | Transfer-control word captured on load or reload |
| src_base | input | 32 | Source start address captured on load or reload |
| dst_base | input | 32 | Destination start address captured on load or reload |
| desc_load | input | 1 | Load pulse for a new descriptor |
| periph_req | input | 1 | Peripheral pacing request |
| hw_trig | input | 1 | Raw hardware trigger |
| abort | input | 1 | Abort the channel |
| req_ready | input | 1 | Fabric accepts the current request |
| reload_ack | input | 1 | Acknowledge for reload_req, descriptor presented on inputs |
| req_valid | output | 1 | Transfer request valid |
| req_src | output | 32 | Source address of the current request |
| req_dst | output | 32 | Destination address of the current request |
| req_width | output | 2 | Width code of the current request |
| done_a | output | 1 | One-cycle completion flag A |
| done_b | output | 1 | One-cycle completion flag B |
| reload_req | output | 1 | Next descriptor wanted |
| chan_stat | output | 3 | Bit 0 valid-pending, bit 2 trigger set, bit 1 zero |
| chan_prio | output | 2 | Exported channel priority |

## Verification
A software-triggered descriptor must show req_valid after the second rising edge following the load edge. The bench therefore samples it at the falling edge before that and at the falling edge after. A hardware trigger adds two more edges: one to register the pin and one to set the flag. An abort takes effect at the next edge, and done pulses come one edge after the final accepted request. All inputs change one nanosecond after a rising edge. Every request, done pulse and status value is sampled at falling edges and logged there. Each scenario then waits a margin well past the latest due edge before comparing counts and addresses against values computed from the requirement text.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int BURST_POW_MAX = 10;
  localparam int BURST_CNT_W   = BURST_POW_MAX + 1;
  localparam int STEP_W        = 5;

  // configuration word fields
  localparam int CF_PERIPH   = 0;
  localparam int CF_HWTRIG   = 1;
  localparam int CF_POL      = 4;
  localparam int CF_LEVEL    = 5;
  localparam int CF_BURST    = 6;
  localparam int CF_BPOW_LO  = 8;
  localparam int CF_SWRAP    = 14;
  localparam int CF_DWRAP    = 15;
  localparam int CF_PRIO_LO  = 16;

  // transfer-control word fields
  localparam int XF_VALID    = 0;
  localparam int XF_RELOAD   = 1;
  localparam int XF_SWTRIG   = 2;
  localparam int XF_CLRTRIG  = 3;
  localparam int XF_FLAGA    = 4;
  localparam int XF_FLAGB    = 5;
  localparam int XF_WID_LO   = 8;
  localparam int XF_SINC_LO  = 12;
  localparam int XF_DINC_LO  = 14;
  localparam int XF_CNT_LO   = 16;
  localparam int XF_CNT_W    = 10;

  // bytes moved per step: increment code scales the element width
  function automatic logic [STEP_W-1:0] step_bytes(input logic [1:0] inc_code,
                                                   input logic [1:0] wid_code);
    logic [1:0] w;
    w = (wid_code == 2'd3) ? 2'd2 : wid_code;
    if (inc_code == 2'd0) return '0;
    return STEP_W'((5'd1 << (inc_code - 2'd1)) << w);
  endfunction

  // requests in one burst, exponent clamped to the legal maximum
  function automatic logic [BURST_CNT_W-1:0] burst_beats(input logic [3:0] pow);
    logic [3:0] p;
    p = (pow > 4'(BURST_POW_MAX)) ? 4'(BURST_POW_MAX) : pow;
    return BURST_CNT_W'(1) << p;
  endfunction
endpackage

// File: rtl/dma_trig_cond.sv
module dma_trig_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic active_high,
  input  logic level_mode,
  input  logic arm,
  output logic evt,
  output logic edge_seen
);
  logic trig_s, trig_s2;
  logic hit, was;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_s  <= 1'b0;
      trig_s2 <= 1'b0;
    end else begin
      trig_s  <= trig_in;
      trig_s2 <= trig_s;
    end
  end

  assign hit       = (trig_s == active_high);
  assign was       = (trig_s2 == active_high);
  assign edge_seen = hit & ~was;
  assign evt       = arm & (level_mode ? hit : edge_seen);

  // R5: an edge with unchanged polarity cannot be reported on two adjacent cycles
  a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (!$stable(active_high) || !edge_seen));
endmodule

// File: rtl/dma_addr_walker.sv
module dma_addr_walker #(
  parameter int AW = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          beat,
  input  logic [SW-1:0] step,
  input  logic          wrap,
  input  logic          burst_start,
  input  logic          burst_end,
  output logic [AW-1:0] addr,
  output logic          wrap_evt
);
  logic [AW-1:0] origin;

  assign wrap_evt = beat & burst_end & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      origin <= '0;
    end else if (load) begin
      addr   <= base;
      origin <= base;
    end else begin
      if (burst_start) origin <= addr;
      if (wrap_evt)    addr <= origin;
      else if (beat)   addr <= addr + AW'(step);
    end
  end

  // R7: a wrapping burst end puts the address back at the burst start
  a_r7_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load) |=> addr == $past(origin));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] xfer_word,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     dst_base,
  input  logic              desc_load,
  input  logic              periph_req,
  input  logic              hw_trig,
  input  logic              abort,
  input  logic              req_ready,
  input  logic              reload_ack,
  output logic              req_valid,
  output logic [AW-1:0]     req_src,
  output logic [AW-1:0]     req_dst,
  output logic [1:0]        req_width,
  output logic              done_a,
  output logic              done_b,
  output logic              reload_req,
  output logic [2:0]        chan_stat,
  output logic [1:0]        chan_prio
);
  localparam int SIDES = 2;

  logic [WORD_W-1:0]      xf_q;
  logic                   valid_q, trig_q, trig_d, in_burst_q;
  logic [XF_CNT_W-1:0]    rem_q;
  logic [BURST_CNT_W-1:0] bleft_q;

  // named internal events
  logic load_now, beat, last_beat, burst_fin, start_burst, trig_evt, edge_seen;
  logic hw_mode;

  assign hw_mode     = cfg_word[CF_HWTRIG];
  assign load_now    = desc_load | (reload_req & reload_ack);
  assign req_valid   = in_burst_q & chan_en & ~abort &
                       (~cfg_word[CF_PERIPH] | periph_req);
  assign beat        = req_valid & req_ready;
  assign last_beat   = beat & (rem_q == '0);
  assign burst_fin   = beat & ((bleft_q == '0) | (rem_q == '0));
  assign start_burst = valid_q & trig_q & ~in_burst_q & ~abort & ~load_now;

  dma_trig_cond u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_in    (hw_trig),
    .active_high(cfg_word[CF_POL]),
    .level_mode (cfg_word[CF_LEVEL]),
    .arm        (hw_mode & valid_q),
    .evt        (trig_evt),
    .edge_seen  (edge_seen)
  );

  always_comb begin
    trig_d = trig_q;
    if (burst_fin & hw_mode)           trig_d = 1'b0;
    if (last_beat & xf_q[XF_CLRTRIG])  trig_d = 1'b0;
    if (load_now & xfer_word[XF_SWTRIG]) trig_d = 1'b1;
    if (trig_evt)                      trig_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xf_q <= '0; valid_q <= 1'b0; trig_q <= 1'b0; in_burst_q <= 1'b0;
      rem_q <= '0; bleft_q <= '0; reload_req <= 1'b0;
      done_a <= 1'b0; done_b <= 1'b0;
    end else if (abort) begin
      valid_q <= 1'b0; trig_q <= 1'b0; in_burst_q <= 1'b0;
      rem_q <= '0; bleft_q <= '0; reload_req <= 1'b0;
      done_a <= 1'b0; done_b <= 1'b0;
    end else begin
      done_a <= last_beat & xf_q[XF_FLAGA];
      done_b <= last_beat & xf_q[XF_FLAGB];
      trig_q <= trig_d;
      if (load_now) begin
        xf_q       <= xfer_word;
        valid_q    <= xfer_word[XF_VALID];
        rem_q      <= xfer_word[XF_CNT_LO +: XF_CNT_W];
        reload_req <= 1'b0;
      end else begin
        if (last_beat) begin
          valid_q    <= 1'b0;
          reload_req <= xf_q[XF_RELOAD];
        end
        if (beat && rem_q != '0) rem_q <= rem_q - 1'b1;
      end
      if (start_burst) begin
        in_burst_q <= 1'b1;
        bleft_q    <= cfg_word[CF_BURST] ?
                      burst_beats(cfg_word[CF_BPOW_LO +: 4]) - 1'b1 : '0;
      end else if (burst_fin) begin
        in_burst_q <= 1'b0;
      end else if (beat) begin
        bleft_q <= bleft_q - 1'b1;
      end
    end
  end

  // source and destination walkers share one structure
  logic [AW-1:0]     base_a [SIDES];
  logic [STEP_W-1:0] step_a [SIDES];
  logic              wrap_a [SIDES];
  logic [AW-1:0]     addr_a [SIDES];
  logic              wev_a  [SIDES];

  assign base_a[0] = src_base;
  assign base_a[1] = dst_base;
  assign step_a[0] = step_bytes(xf_q[XF_SINC_LO +: 2], xf_q[XF_WID_LO +: 2]);
  assign step_a[1] = step_bytes(xf_q[XF_DINC_LO +: 2], xf_q[XF_WID_LO +: 2]);
  assign wrap_a[0] = cfg_word[CF_SWRAP];
  assign wrap_a[1] = cfg_word[CF_DWRAP];

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_addr_walker #(.AW(AW), .SW(STEP_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_now),
      .base       (base_a[g]),
      .beat       (beat),
      .step       (step_a[g]),
      .wrap       (wrap_a[g]),
      .burst_start(start_burst),
      .burst_end  (burst_fin),
      .addr       (addr_a[g]),
      .wrap_evt   (wev_a[g])
    );
  end

  assign req_src   = addr_a[0];
  assign req_dst   = addr_a[1];
  assign req_width = xf_q[XF_WID_LO +: 2];
  assign chan_stat = {trig_q, 1'b0, valid_q};
  assign chan_prio = cfg_word[CF_PRIO_LO +: 2];

  a_r8_periph_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[CF_PERIPH] && !periph_req) |-> !req_valid);
  a_r12_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !req_valid);
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!req_valid && chan_stat == 3'b000 && !reload_req));
  a_r9_last_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !load_now) |=> !chan_stat[0]);
  a_r6_burst_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_fin && !abort) |=> !req_valid);
  a_r10_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_req && !reload_ack && !abort) |=> reload_req);
  a_r2_valid_needs_desc: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> chan_stat[0]);
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b1;
  logic [31:0] cfg_word = '0, xfer_word = '0, src_base = '0, dst_base = '0;
  logic desc_load = 1'b0, periph_req = 1'b0, hw_trig = 1'b0, abort = 1'b0;
  logic req_ready = 1'b1, reload_ack = 1'b0;
  logic req_valid, done_a, done_b, reload_req;
  logic [31:0] req_src, req_dst;
  logic [1:0] req_width, chan_prio;
  logic [2:0] chan_stat;

  int total = 0, bad = 0, nbeat = 0, nda = 0, ndb = 0;
  bit finished = 0;
  logic [31:0] slog [0:1099];
  logic [31:0] dlog [0:1099];

  always #10 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_word(cfg_word),
    .xfer_word(xfer_word), .src_base(src_base), .dst_base(dst_base),
    .desc_load(desc_load), .periph_req(periph_req), .hw_trig(hw_trig),
    .abort(abort), .req_ready(req_ready), .reload_ack(reload_ack),
    .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
    .req_width(req_width), .done_a(done_a), .done_b(done_b),
    .reload_req(reload_req), .chan_stat(chan_stat), .chan_prio(chan_prio)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin
        if (nbeat < 1100) begin
          slog[nbeat] = req_src;
          dlog[nbeat] = req_dst;
        end
        nbeat = nbeat + 1;
      end
      if (done_a) nda = nda + 1;
      if (done_b) ndb = ndb + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkx(input bit rl, input bit sw, input bit clr,
      input bit fa, input bit fb, input int wid, input int si, input int di, input int cnt);
    logic [31:0] x;
    x = 32'h1;
    x[1] = rl; x[2] = sw; x[3] = clr; x[4] = fa; x[5] = fb;
    x[9:8] = wid[1:0]; x[13:12] = si[1:0]; x[15:14] = di[1:0];
    x[25:16] = 10'(cnt - 1);
    return x;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic trig_level);
    @(posedge clk); #1;
    rst_n = 1'b0; chan_en = 1'b1; desc_load = 1'b0; abort = 1'b0;
    periph_req = 1'b0; req_ready = 1'b1; reload_ack = 1'b0; hw_trig = trig_level;
    cfg_word = '0; xfer_word = '0;
    cyc(3);
    rst_n = 1'b1;
    nbeat = 0; nda = 0; ndb = 0;
    cyc(2);
  endtask

  task automatic load(input logic [31:0] x, input logic [31:0] s, input logic [31:0] d);
    xfer_word = x; src_base = s; dst_base = d; desc_load = 1'b1;
    cyc(1);
    desc_load = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    @(negedge clk);
    check("R1 req_valid", req_valid, 0);
    check("R1 done", {done_a, done_b, reload_req}, 0);
    check("R1 stat", chan_stat, 0);
  endtask

  task automatic t_sw_single;
    do_reset(1'b0);
    load(mkx(0,1,1,1,0,2,1,0,4), 32'h1000, 32'h2000);
    @(negedge clk);
    check("R2 stat after load", chan_stat, 3'b101);
    check("R2 no req at edge+1", req_valid, 0);
    @(negedge clk);
    check("R2 req at edge+2", req_valid, 1);
    cyc(30);
    check("R3 count 4", nbeat, 4);
    for (int i = 0; i < 4; i++) begin
      check("R4 src step 4", slog[i], 32'h1000 + 4 * i);
      check("R4 dst fixed", dlog[i], 32'h2000);
    end
    check("R9 done_a once", nda, 1);
    check("R9 done_b none", ndb, 0);
    check("R9 stat cleared", chan_stat, 0);
  endtask

  task automatic t_long;
    do_reset(1'b0);
    load(mkx(0,1,0,0,0,1,3,2,1024), 32'h1000, 32'h8000);
    cyc(2200);
    check("R3 count 1024", nbeat, 1024);
    check("R4 src width16 inc4", slog[1023], 32'h1000 + 8 * 1023);
    check("R4 dst width16 inc2", dlog[1023], 32'h8000 + 4 * 1023);
    check("R9 trig kept without clear bit", chan_stat, 3'b100);
  endtask

  task automatic t_burst_wrap;
    do_reset(1'b0);
    cfg_word = 32'h0 | (1 << 1) | (1 << 4) | (1 << 6) | (2 << 8) | (1 << 14);
    load(mkx(0,0,0,0,1,0,1,1,8), 32'h1000, 32'h2000);
    cyc(10);
    check("R5 no req before trigger", nbeat, 0);
    hw_trig = 1'b1; cyc(3); hw_trig = 1'b0;
    cyc(20);
    check("R6 one burst of 4", nbeat, 4);
    for (int i = 0; i < 4; i++) check("R6 burst src", slog[i], 32'h1000 + i);
    hw_trig = 1'b1; cyc(3); hw_trig = 1'b0;
    cyc(20);
    check("R6 second burst", nbeat, 8);
    for (int i = 4; i < 8; i++) begin
      check("R7 src wrapped", slog[i], 32'h1000 + (i - 4));
      check("R7 dst not wrapped", dlog[i], 32'h2000 + i);
    end
    check("R9 done_b once", ndb, 1);
    check("R9 done_a none", nda, 0);
  endtask

  task automatic t_level_low;
    int n1;
    do_reset(1'b1);
    cfg_word = (1 << 1) | (1 << 5);
    load(mkx(0,0,0,0,0,2,1,1,100), 32'h0, 32'h100);
    cyc(10);
    check("R5 inactive level no req", nbeat, 0);
    hw_trig = 1'b0; cyc(20);
    hw_trig = 1'b1; cyc(10);
    n1 = nbeat;
    check("R5 level ran", (n1 > 0 && n1 < 100), 1);
    cyc(10);
    check("R5 level released stops", nbeat, n1);
  endtask

  task automatic t_falling;
    do_reset(1'b0);
    cfg_word = (1 << 1) | (1 << 6) | (1 << 8);
    load(mkx(0,0,0,0,0,0,1,1,10), 32'h0, 32'h100);
    hw_trig = 1'b1; cyc(20);
    check("R5 rising ignored in falling mode", nbeat, 0);
    hw_trig = 1'b0; cyc(20);
    check("R5 falling edge burst of 2", nbeat, 2);
  endtask

  task automatic t_abort;
    int n1;
    do_reset(1'b0);
    load(mkx(0,1,0,1,0,2,1,1,50), 32'h0, 32'h400);
    cyc(12);
    abort = 1'b1;
    @(negedge clk);
    check("R11 req drops with abort", req_valid, 0);
    cyc(1);
    abort = 1'b0;
    @(negedge clk);
    check("R11 stat cleared", chan_stat, 0);
    n1 = nbeat;
    chan_en = 1'b0; cyc(2); chan_en = 1'b1; cyc(20);
    check("R11 no resume", nbeat, n1);
    check("R11 no done", nda, 0);
  endtask

  task automatic t_periph;
    do_reset(1'b0);
    cfg_word = 32'h1;
    load(mkx(0,1,0,0,0,0,1,1,3), 32'h0, 32'h0);
    cyc(10);
    check("R8 held without request", nbeat, 0);
    check("R8 state kept", chan_stat, 3'b101);
    periph_req = 1'b1; cyc(20);
    check("R8 runs with request", nbeat, 3);
  endtask

  task automatic t_enable_prio;
    do_reset(1'b0);
    cfg_word = 32'h0002_0000;
    chan_en = 1'b0;
    load(mkx(0,1,0,0,0,0,1,1,2), 32'h0, 32'h0);
    cyc(10);
    check("R12 disabled no req", nbeat, 0);
    check("R12 state kept", chan_stat[0], 1);
    check("R12 priority", chan_prio, 2'd2);
    chan_en = 1'b1; cyc(10);
    check("R12 enabled runs", nbeat, 2);
  endtask

  task automatic t_reload;
    do_reset(1'b0);
    load(mkx(1,1,0,1,0,2,1,1,2), 32'h100, 32'h200);
    cyc(10);
    check("R10 reload_req raised", reload_req, 1);
    check("R10 valid gone", chan_stat[0], 0);
    cyc(3);
    check("R10 reload_req held", reload_req, 1);
    xfer_word = mkx(0,1,0,0,1,2,1,1,3); src_base = 32'h3000; dst_base = 32'h4000;
    reload_ack = 1'b1; cyc(1); reload_ack = 1'b0;
    @(negedge clk);
    check("R10 reload_req dropped", reload_req, 0);
    cyc(15);
    check("R10 total beats", nbeat, 5);
    check("R10 new src", slog[2], 32'h3000);
    check("R10 new dst", dlog[4], 32'h4008);
    check("R10 flags", {nda[3:0], ndb[3:0]}, 8'h11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sw_single();
    t_long();
    t_burst_wrap();
    t_level_low();
    t_falling();
    t_abort();
    t_periph();
    t_enable_prio();
    t_reload();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule